// File: doc/BRIEF.md
# Multi-Harmonic Sine Synthesizer

This block builds one waveform sample from a bank of eight sine harmonics. Each harmonic keeps its own 12-bit phase. On every base-rate tick, harmonic k moves its phase forward by k steps, so the eight waves run at one to eight times the base rate. A computed sine shaper turns each phase into a signed 16-bit value.

Every harmonic has two unsigned amplitude inputs, one that adds and one that subtracts. The subtracting bank does not use signed amplitudes. It reads a second, inverted sine path that evaluates the shaper half a turn later. All sixteen products are summed into one sample register. The register loads on the clock edge where the tick is high. The sum wraps modulo the output width and is never clipped.

A sequencer or timer supplies the tick. The sixteen amplitude values come from registers outside this block. The output feeds a modulator or DAC that runs at the tick rate.

Top module: `harmonic_synth`

## Requirements
- R1: While reset is active, all phases and the output sample are zero. The first sample after reset is therefore 0 for any amplitudes, because every phase is 0.
- R2: On each clock edge with `tick_i` high, the phase of harmonic k (k = 1..8) grows by k, modulo 4096. With `tick_i` low, every phase holds.
- R3: The sine of a 12-bit phase p is defined as follows. Let h = p mod 2048 and m = floor(h*(2048-h)/64), where 0 <= m <= 16384. The sine is +m when p < 2048 and -m otherwise.
- R4: The positive term of harmonic k is sine(phase_k) times P_k, where P_k is the unsigned 8-bit value in `amp_pos_i`. No normalization is applied.
- R5: The negative term of harmonic k is sine(phase_k + 2048) times N_k, which equals -sine(phase_k) times N_k. N_k is the unsigned 8-bit value in `amp_neg_i`.
- R6: `sample_o` is the sum of all sixteen terms, modulo 2^24, as a two's-complement value. A sum outside the 24-bit range wraps and is not saturated.
- R7: `sample_o` loads only on a clock edge with `tick_i` high. It is computed from the phases and amplitudes present before that edge's phase advance. Between ticks, it holds, even if the amplitudes change.
- R8: Harmonic k (1..8) takes its amplitudes from bits [8k-1:8(k-1)] of `amp_pos_i` and of `amp_neg_i`.
- R9: Pulling `rst_ni` low clears `sample_o` at once, without waiting for a clock edge. Release passes through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base-rate step; one sample per high cycle |
| amp_pos_i | input | 64 | Eight unsigned 8-bit additive amplitudes, harmonic 1 in the low byte |
| amp_neg_i | input | 64 | Eight unsigned 8-bit subtractive amplitudes, harmonic 1 in the low byte |
| sample_o | output | 24 | Wrapped two's-complement sum of all scaled harmonics |

## Verification
The hardest case to reach from the ports is a true sum that falls outside the 24-bit range. The wrap only shows when many harmonics peak together with large amplitudes. The bench drives every additive amplitude to full scale with the subtractive bank at zero, and sweeps a quarter period of the base phase. At small base angles the harmonics add in phase, well past the output range. The bench confirms that such sums occurred and that each one matches its modulo value. The other sweeps cover every harmonic alone for 512 ticks, and a full 4096-tick period with mixed amplitudes on both banks. The bench also checks that amplitude changes between ticks leave the output unchanged, and that a reset in the middle of a run clears the output.

// File: rtl/harmonic_synth_pkg.sv
package harmonic_synth_pkg;
  localparam int PHASE_W = 12;
  localparam int SINE_W  = 16;

  typedef logic        [PHASE_W-1:0] phase_t;
  typedef logic signed [SINE_W-1:0]  sine_t;

  // Peak magnitude of the computed sine: (2^(PHASE_W-2))^2 >> SHAPE_SHIFT
  localparam int SHAPE_SHIFT = 2*(PHASE_W-2) - (SINE_W-2);
  localparam int SINE_PEAK   = 1 << (SINE_W-2);
endpackage

// File: rtl/hs_reset_sync.sv
module hs_reset_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/hs_phase_accum.sv
module hs_phase_accum
  import harmonic_synth_pkg::*;
#(
  parameter int STEP = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  output phase_t phase_o
);
  localparam phase_t STEP_V = phase_t'(STEP);

  phase_t phase_q;
  phase_t phase_d;

  always_comb begin
    phase_d = phase_q;
    if (tick_i) phase_d = phase_q + STEP_V;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tick_i) && $past(rst_ni)) |-> (phase_q == phase_t'($past(phase_q) + STEP_V)));

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(phase_q));
endmodule

// File: rtl/hs_sine_shaper.sv
module hs_sine_shaper
  import harmonic_synth_pkg::*;
(
  input  phase_t phase_i,
  output sine_t  sine_o
);
  localparam phase_t HALF_TURN = phase_t'(1 << (PHASE_W-1));

  phase_t                   h_ext;
  phase_t                   comp;
  logic [2*PHASE_W-1:0]     prod;
  logic [SINE_W-1:0]        mag;

  always_comb begin
    h_ext  = {1'b0, phase_i[PHASE_W-2:0]};
    comp   = HALF_TURN - h_ext;
    prod   = (2*PHASE_W)'(h_ext) * (2*PHASE_W)'(comp);
    mag    = SINE_W'(prod >> SHAPE_SHIFT);
    sine_o = phase_i[PHASE_W-1] ? sine_t'(-mag) : sine_t'(mag);
  end
endmodule

// File: rtl/hs_term_scaler.sv
module hs_term_scaler
  import harmonic_synth_pkg::*;
#(
  parameter int AMP_W  = 8,
  parameter int TERM_W = SINE_W + AMP_W + 1
) (
  input  sine_t                    sine_i,
  input  logic [AMP_W-1:0]         amp_i,
  output logic signed [TERM_W-1:0] term_o
);
  logic signed [TERM_W-1:0] s_ext;
  logic signed [TERM_W-1:0] a_ext;

  always_comb begin
    s_ext  = TERM_W'(sine_i);
    a_ext  = $signed(TERM_W'(amp_i));
    term_o = s_ext * a_ext;
  end
endmodule

// File: rtl/harmonic_synth.sv
module harmonic_synth
  import harmonic_synth_pkg::*;
#(
  parameter int NUM_HARM = 8,
  parameter int AMP_W    = 8,
  parameter int OUT_W    = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic [NUM_HARM*AMP_W-1:0] amp_pos_i,
  input  logic [NUM_HARM*AMP_W-1:0] amp_neg_i,
  output logic signed [OUT_W-1:0]   sample_o
);
  localparam int     TERM_W    = SINE_W + AMP_W + 1;
  localparam int     ACC_W     = (OUT_W > TERM_W) ? OUT_W : TERM_W;
  localparam phase_t HALF_TURN = phase_t'(1 << (PHASE_W-1));

  logic rst_n_sync;

  phase_t                   ph       [NUM_HARM];
  sine_t                    sin_pos  [NUM_HARM];
  sine_t                    sin_neg  [NUM_HARM];
  logic signed [TERM_W-1:0] term_pos [NUM_HARM];
  logic signed [TERM_W-1:0] term_neg [NUM_HARM];

  logic signed [ACC_W-1:0]  acc;
  logic signed [OUT_W-1:0]  sample_q;
  logic signed [OUT_W-1:0]  sample_d;

  hs_reset_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_sync)
  );

  for (genvar k = 0; k < NUM_HARM; k++) begin : g_harm
    hs_phase_accum #(.STEP(k+1)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_n_sync),
      .tick_i  (tick_i),
      .phase_o (ph[k])
    );

    hs_sine_shaper u_sin_pos (
      .phase_i (ph[k]),
      .sine_o  (sin_pos[k])
    );

    // Inverted path: the same shaper read half a turn later
    hs_sine_shaper u_sin_neg (
      .phase_i (ph[k] ^ HALF_TURN),
      .sine_o  (sin_neg[k])
    );

    hs_term_scaler #(.AMP_W(AMP_W), .TERM_W(TERM_W)) u_scl_pos (
      .sine_i (sin_pos[k]),
      .amp_i  (amp_pos_i[k*AMP_W +: AMP_W]),
      .term_o (term_pos[k])
    );

    hs_term_scaler #(.AMP_W(AMP_W), .TERM_W(TERM_W)) u_scl_neg (
      .sine_i (sin_neg[k]),
      .amp_i  (amp_neg_i[k*AMP_W +: AMP_W]),
      .term_o (term_neg[k])
    );

    // R5
    mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
      (sin_pos[k] + sin_neg[k]) == sine_t'(0));

    // R3
    bound_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
      (sin_pos[k] <= sine_t'(SINE_PEAK)) && (sin_pos[k] >= -sine_t'(SINE_PEAK)));

    // R2
    align_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
      ph[k] == phase_t'(ph[0] * phase_t'(k+1)));
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NUM_HARM; i++) begin
      acc = acc + ACC_W'(term_pos[i]) + ACC_W'(term_neg[i]);
    end
  end

  always_comb begin
    sample_d = sample_q;
    if (tick_i) sample_d = OUT_W'(acc);
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) sample_q <= '0;
    else             sample_q <= sample_d;
  end

  assign sample_o = sample_q;

  // R7
  sample_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    !$past(tick_i) |-> $stable(sample_q));

  // R1
  first_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (!$past(rst_n_sync)) |-> (sample_q == '0));
endmodule

// File: tb/sim_harmonic_synth.sv
`timescale 1ns/1ps
module sim_harmonic_synth;
  localparam int NH = 8;
  localparam int AW = 8;
  localparam int OW = 24;

  logic               clk_i = 1'b0;
  logic               rst_ni;
  logic               tick_i;
  logic [NH*AW-1:0]   amp_pos_i;
  logic [NH*AW-1:0]   amp_neg_i;
  logic signed [OW-1:0] sample_o;

  int total = 0;
  int bad   = 0;
  int n_ticks;
  int pos_a [NH];
  int neg_a [NH];
  bit wrap_seen = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  harmonic_synth u0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .amp_pos_i (amp_pos_i),
    .amp_neg_i (amp_neg_i),
    .sample_o  (sample_o)
  );

  function automatic longint sine_ref(int p);
    int h;
    longint m;
    h = p % 2048;
    m = (longint'(h) * longint'(2048 - h)) / 64;
    return (p >= 2048) ? -m : m;
  endfunction

  function automatic longint true_sum(int n);
    longint s = 0;
    for (int k = 1; k <= NH; k++) begin
      int ph = (k * n) % 4096;
      s += sine_ref(ph) * pos_a[k-1];
      s -= sine_ref(ph) * neg_a[k-1];
    end
    return s;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_amps();
    for (int k = 0; k < NH; k++) begin
      amp_pos_i[k*AW +: AW] = AW'(pos_a[k]);
      amp_neg_i[k*AW +: AW] = AW'(neg_a[k]);
    end
  endtask

  // One tick; the sample appears after the edge that sees tick high
  task automatic do_tick(input string req);
    longint s;
    longint exp_bits;
    @(negedge clk_i);
    apply_amps();
    tick_i = 1'b1;
    s = true_sum(n_ticks);
    @(negedge clk_i);
    tick_i = 1'b0;
    if (s > 64'sd8388607 || s < -64'sd8388608) wrap_seen = 1;
    exp_bits = s & 64'hFF_FFFF;
    check(req, longint'(unsigned'(sample_o)), exp_bits);
    n_ticks++;
  endtask

  task automatic clear_amps();
    for (int k = 0; k < NH; k++) begin
      pos_a[k] = 0;
      neg_a[k] = 0;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni    = 1'b0;
    tick_i    = 1'b0;
    amp_pos_i = '0;
    amp_neg_i = '0;
    clear_amps();
    repeat (3) @(negedge clk_i);
    // R1: output zero while reset is held
    check("R1 reset value", longint'(unsigned'(sample_o)), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    n_ticks = 0;

    // R1: first sample after reset is 0 despite nonzero amplitudes
    for (int k = 0; k < NH; k++) begin
      pos_a[k] = 100 + k;
      neg_a[k] = 7 * k;
    end
    do_tick("R1 first sample");

    // R4/R8/R3/R2: each harmonic alone in its own byte
    for (int k = 0; k < NH; k++) begin
      clear_amps();
      pos_a[k] = 200;
      for (int t = 0; t < 512; t++) do_tick("R4 R8 R2 R3 single harmonic");
    end

    // R5: subtractive bank alone
    clear_amps();
    neg_a[2] = 255;
    neg_a[5] = 17;
    for (int t = 0; t < 256; t++) do_tick("R5 subtractive bank");

    // R6/R5: full period with mixed amplitudes on both banks
    for (int k = 0; k < NH; k++) begin
      pos_a[k] = (37 * k + 11) % 256;
      neg_a[k] = (91 * k + 5) % 256;
    end
    for (int t = 0; t < 4096; t++) do_tick("R6 mixed sum");

    // R6: full-scale additive bank forces the sum past the output range
    n_ticks = n_ticks - (n_ticks % 4096);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    n_ticks = 0;
    for (int k = 0; k < NH; k++) begin
      pos_a[k] = 255;
      neg_a[k] = 0;
    end
    for (int t = 0; t < 1024; t++) do_tick("R6 wrap sweep");
    check("R6 wrap exercised", longint'(wrap_seen), 1);

    // R7: amplitude changes with no tick leave the sample unchanged
    begin
      longint held;
      held = longint'(unsigned'(sample_o));
      @(negedge clk_i);
      amp_pos_i = '1;
      amp_neg_i = 64'h0123_4567_89AB_CDEF;
      repeat (5) @(negedge clk_i);
      check("R7 hold between ticks", longint'(unsigned'(sample_o)), held);
      clear_amps();
      pos_a[0] = 9;
      neg_a[7] = 250;
      for (int t = 0; t < 64; t++) begin
        do_tick("R7 R2 phases unaffected by idle cycles");
        @(negedge clk_i);
      end
    end

    // R9: asynchronous clear in mid-run
    #1;
    rst_ni = 1'b0;
    #1;
    check("R9 async clear", longint'(unsigned'(sample_o)), 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    n_ticks = 0;
    for (int k = 0; k < NH; k++) begin
      pos_a[k] = 255 - k;
      neg_a[k] = k;
    end
    do_tick("R1 R9 restart from zero phase");
    for (int t = 0; t < 32; t++) do_tick("R1 R2 phase-aligned restart");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule